// File: doc/BRIEF.md
# I2C Command Transaction Sequencer

This block sits between a user-request source and a byte-level I2C master engine. It turns each high-level request into the ordered list of bus operations that a fixed target device expects. It issues those operations one at a time and waits for the engine's completion handshake before it moves on. The target device is at 7-bit address 0x09. Its address byte is 0x12 for a write and 0x13 for a read.

There are three kinds of request. A digit request sends one data byte to an output port of the target. A block write stores the bytes 1 to 8 starting at pointer 0. A block read sets pointer 0, then uses a repeated start to read eight bytes back. Requests come from a decoded keystroke strobe or from four push-button strobes.

Every request is framed by two short command transactions. One enables the target before the request's body. The other disables it after the body. Read bytes leave the block as a strobed byte stream. If the target rejects an address or write byte, the sequencer aborts the request and flags an error.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Every address byte sent for a write phase is 0x12 (address 0x09 with R/W=0). The address byte after a repeated start is 0x13 (R/W=1).
- R2: An accepted request starts with the transaction START, WRITE 0x12, WRITE 0x06, STOP. Unless aborted, it ends with the transaction START, WRITE 0x12, WRITE 0x04, STOP.
- R3: The body of a digit request with value d is START, WRITE 0x12, WRITE 0x01, WRITE 0x00, WRITE d, STOP.
- R4: The body of a block write is START, WRITE 0x12, WRITE 0x02, WRITE 0x00, WRITE 0x01 through 0x08 in ascending order, STOP.
- R5: The body of a block read is START, WRITE 0x12, WRITE 0x0B, WRITE 0x00, then RSTART, WRITE 0x13, eight READs, STOP, with no stop before the repeated start. Each READ asks for an ACK (eng_rd_ack=1), except the eighth, which asks for a NACK (eng_rd_ack=0).
- R6: A key_valid strobe maps as follows. Characters '0' to '9' (0x30 to 0x39) give a digit request of value 0 to 9. 'w' (0x77) gives a block write, and 'r' (0x72) gives a block read. Any other character is ignored: busy stays low and no operation is issued. btn[2] gives a block write and btn[3] a block read.
- R7: btn[0] gives a digit request with data 0x11 and btn[1] gives one with data 0x22. A matching keystroke has priority over the buttons, and a lower button index has priority over a higher one.
- R8: Suppose the engine completes a WRITE with eng_ack=0. The next operation is then STOP. When that STOP completes, err is high for exactly one cycle, busy falls, and no disable transaction is sent.
- R9: busy is low after reset. It is high from the cycle after a request is accepted until the cycle after the final STOP completes. Requests that arrive while busy is high are ignored.
- R10: The byte on eng_rdata at each completed READ appears on rd_data, with rd_valid high for exactly one cycle, one clock after the completion. Bytes come out in the order they were received.
- R11: eng_req is high only while busy. Once raised, eng_op and eng_wdata hold steady until the cycle in which eng_done is seen. Operation codes are START=0, RSTART=1, STOP=2, WRITE=3, READ=4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_valid | input | 1 | One-cycle strobe: key_char holds a decoded keystroke |
| key_char | input | 8 | ASCII code of the keystroke |
| btn | input | 4 | Push-button request strobes |
| eng_req | output | 1 | An engine operation is requested and held |
| eng_op | output | 3 | Operation code (START=0, RSTART=1, STOP=2, WRITE=3, READ=4) |
| eng_wdata | output | 8 | Byte to send for WRITE |
| eng_rd_ack | output | 1 | For READ: 1 sends ACK, 0 sends NACK after the byte |
| eng_done | input | 1 | One-cycle strobe: the requested operation finished |
| eng_ack | input | 1 | With eng_done after WRITE: 1 if the target acknowledged |
| eng_rdata | input | 8 | With eng_done after READ: received byte |
| busy | output | 1 | A request is in progress |
| err | output | 1 | One-cycle pulse: request aborted on a NACK |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | 8 | Received read byte |

## Verification
Each request is driven through both of its sources: keystrokes '3', '9', 'w' and 'r', and all four buttons. The full logged operation list is compared entry by entry, which separates digit, write and read bodies and exposes a wrong command byte, pointer, data order or address bit. A read returns distinct bytes, so the rd_data stream shows the ordering and the eighth-byte NACK. Other patterns cover an unmapped character, requests arriving while busy, and a NACK on the body's address byte, which must end with a stop, an error pulse and no disable transaction.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4
  } eng_op_t;

  typedef enum logic [1:0] {
    RQ_DIGIT  = 2'd0,
    RQ_BWRITE = 2'd1,
    RQ_BREAD  = 2'd2
  } req_kind_t;

  typedef enum logic [1:0] {
    PH_ENABLE  = 2'd0,
    PH_BODY    = 2'd1,
    PH_DISABLE = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ABORT = 2'd2
  } seq_state_t;

  localparam logic [7:0] CMD_ENABLE  = 8'h06;
  localparam logic [7:0] CMD_DISABLE = 8'h04;
  localparam logic [7:0] CMD_DIGIT   = 8'h01;
  localparam logic [7:0] CMD_BWRITE  = 8'h02;
  localparam logic [7:0] CMD_BREAD   = 8'h0B;

endpackage

// File: rtl/i2cseq_req_decode.sv
module i2cseq_req_decode
  import i2cseq_pkg::*;
#(
  parameter logic [7:0] BTN0_DATA = 8'h11,
  parameter logic [7:0] BTN1_DATA = 8'h22
) (
  input  logic       key_valid,
  input  logic [7:0] key_char,
  input  logic [3:0] btn,
  output logic       req_valid,
  output req_kind_t  req_kind,
  output logic [7:0] req_digit
);

  logic key_is_num;
  logic key_is_w;
  logic key_is_r;

  always_comb begin
    key_is_num = key_valid && (key_char >= 8'h30) && (key_char <= 8'h39);
    key_is_w   = key_valid && (key_char == 8'h77);
    key_is_r   = key_valid && (key_char == 8'h72);
  end

  always_comb begin
    req_valid = 1'b1;
    req_kind  = RQ_DIGIT;
    req_digit = 8'h00;
    if (key_is_num) begin
      req_digit = key_char - 8'h30;
    end else if (key_is_w) begin
      req_kind = RQ_BWRITE;
    end else if (key_is_r) begin
      req_kind = RQ_BREAD;
    end else if (btn[0]) begin
      req_digit = BTN0_DATA;
    end else if (btn[1]) begin
      req_digit = BTN1_DATA;
    end else if (btn[2]) begin
      req_kind = RQ_BWRITE;
    end else if (btn[3]) begin
      req_kind = RQ_BREAD;
    end else begin
      req_valid = 1'b0;
    end
  end

endmodule

// File: rtl/i2cseq_step_gen.sv
module i2cseq_step_gen
  import i2cseq_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h09,
  parameter int unsigned BLK_LEN   = 8,
  parameter logic [7:0]  START_PTR = 8'h00,
  parameter logic [7:0]  GPO_PORT  = 8'h00,
  parameter int unsigned IW        = 4
) (
  input  phase_t        phase,
  input  req_kind_t     kind,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    digit,
  output eng_op_t       op,
  output logic [7:0]    wbyte,
  output logic          rd_ack,
  output logic          last
);

  localparam logic [7:0]    ADDR_W   = {DEV_ADDR, 1'b0};
  localparam logic [7:0]    ADDR_R   = {DEV_ADDR, 1'b1};
  localparam logic [IW-1:0] IX_WSTOP = IW'(4 + BLK_LEN);
  localparam logic [IW-1:0] IX_RLAST = IW'(5 + BLK_LEN);
  localparam logic [IW-1:0] IX_RSTOP = IW'(6 + BLK_LEN);

  logic [7:0] cmd;

  always_comb begin
    if (phase == PH_ENABLE)       cmd = CMD_ENABLE;
    else if (phase == PH_DISABLE) cmd = CMD_DISABLE;
    else if (kind == RQ_BWRITE)   cmd = CMD_BWRITE;
    else if (kind == RQ_BREAD)    cmd = CMD_BREAD;
    else                          cmd = CMD_DIGIT;
  end

  always_comb begin
    op     = OP_WRITE;
    wbyte  = 8'h00;
    rd_ack = 1'b1;
    last   = 1'b0;
    if (idx == IW'(0)) begin
      op = OP_START;
    end else if (idx == IW'(1)) begin
      wbyte = ADDR_W;
    end else if (idx == IW'(2)) begin
      wbyte = cmd;
    end else if (phase != PH_BODY) begin
      op   = OP_STOP;
      last = 1'b1;
    end else if (idx == IW'(3)) begin
      wbyte = (kind == RQ_DIGIT) ? GPO_PORT : START_PTR;
    end else if (kind == RQ_DIGIT) begin
      if (idx == IW'(4)) begin
        wbyte = digit;
      end else begin
        op   = OP_STOP;
        last = 1'b1;
      end
    end else if (kind == RQ_BWRITE) begin
      if (idx < IX_WSTOP) begin
        wbyte = 8'(idx) - 8'd3;
      end else begin
        op   = OP_STOP;
        last = 1'b1;
      end
    end else begin
      if (idx == IW'(4)) begin
        op = OP_RSTART;
      end else if (idx == IW'(5)) begin
        wbyte = ADDR_R;
      end else if (idx < IX_RSTOP) begin
        op     = OP_READ;
        rd_ack = (idx != IX_RLAST);
      end else begin
        op   = OP_STOP;
        last = 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cseq_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h09,
  parameter int unsigned BLK_LEN   = 8,
  parameter logic [7:0]  START_PTR = 8'h00,
  parameter logic [7:0]  GPO_PORT  = 8'h00,
  parameter logic [7:0]  BTN0_DATA = 8'h11,
  parameter logic [7:0]  BTN1_DATA = 8'h22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  input  logic [7:0] key_char,
  input  logic [3:0] btn,
  output logic       eng_req,
  output logic [2:0] eng_op,
  output logic [7:0] eng_wdata,
  output logic       eng_rd_ack,
  input  logic       eng_done,
  input  logic       eng_ack,
  input  logic [7:0] eng_rdata,
  output logic       busy,
  output logic       err,
  output logic       rd_valid,
  output logic [7:0] rd_data
);

  localparam int unsigned IW = $clog2(BLK_LEN + 8);

  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  logic       req_valid;
  req_kind_t  req_kind;
  logic [7:0] req_digit;

  i2cseq_req_decode #(
    .BTN0_DATA(BTN0_DATA),
    .BTN1_DATA(BTN1_DATA)
  ) u_dec (
    .key_valid(key_valid),
    .key_char (key_char),
    .btn      (btn),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .req_digit(req_digit)
  );

  seq_state_t    state_q, state_d;
  phase_t        phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  req_kind_t     kind_q;
  logic [7:0]    digit_q;
  logic          accept;
  logic          err_d;
  logic          rdv_d;

  eng_op_t    st_op;
  logic [7:0] st_byte;
  logic       st_rd_ack;
  logic       st_last;

  i2cseq_step_gen #(
    .DEV_ADDR (DEV_ADDR),
    .BLK_LEN  (BLK_LEN),
    .START_PTR(START_PTR),
    .GPO_PORT (GPO_PORT),
    .IW       (IW)
  ) u_step (
    .phase (phase_q),
    .kind  (kind_q),
    .idx   (idx_q),
    .digit (digit_q),
    .op    (st_op),
    .wbyte (st_byte),
    .rd_ack(st_rd_ack),
    .last  (st_last)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    accept  = 1'b0;
    err_d   = 1'b0;
    rdv_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_RUN;
          phase_d = PH_ENABLE;
          idx_d   = '0;
        end
      end
      ST_RUN: begin
        if (eng_done) begin
          rdv_d = (st_op == OP_READ);
          if ((st_op == OP_WRITE) && !eng_ack) begin
            state_d = ST_ABORT;
          end else if (st_last) begin
            idx_d = '0;
            if (phase_q == PH_DISABLE) begin
              state_d = ST_IDLE;
            end else if (phase_q == PH_ENABLE) begin
              phase_d = PH_BODY;
            end else begin
              phase_d = PH_DISABLE;
            end
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      ST_ABORT: begin
        if (eng_done) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ENABLE;
      idx_q    <= '0;
      kind_q   <= RQ_DIGIT;
      digit_q  <= 8'h00;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      idx_q    <= idx_d;
      err      <= err_d;
      rd_valid <= rdv_d;
      if (accept) begin
        kind_q  <= req_kind;
        digit_q <= req_digit;
      end
      if (rdv_d) begin
        rd_data <= eng_rdata;
      end
    end
  end

  always_comb begin
    busy       = (state_q != ST_IDLE);
    eng_req    = busy;
    eng_op     = (state_q == ST_ABORT) ? OP_STOP : st_op;
    eng_wdata  = st_byte;
    eng_rd_ack = st_rd_ack;
  end

endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker
  import i2cseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       eng_req,
  input logic [2:0] eng_op,
  input logic [7:0] eng_wdata,
  input logic       eng_done,
  input logic       eng_ack,
  input logic       busy,
  input logic       err,
  input logic       rd_valid
);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata)));

  p_req_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> busy);

  p_stop_after_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && (eng_op == OP_WRITE) && !eng_ack) |=>
      (eng_req && (eng_op == OP_STOP)));

  p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  p_rdv_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(eng_req && eng_done && (eng_op == OP_READ)));

  p_rdv_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

bind i2c_cmd_seq i2cseq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .eng_req  (eng_req),
  .eng_op   (eng_op),
  .eng_wdata(eng_wdata),
  .eng_done (eng_done),
  .eng_ack  (eng_ack),
  .busy     (busy),
  .err      (err),
  .rd_valid (rd_valid)
);

// File: tb/tb_i2c_cmd_seq.sv
`timescale 1ns/1ps
module tb_i2c_cmd_seq;
  import i2cseq_pkg::*;

  logic       clk;
  logic       rst_n;
  logic       key_valid;
  logic [7:0] key_char;
  logic [3:0] btn;
  logic       eng_req;
  logic [2:0] eng_op;
  logic [7:0] eng_wdata;
  logic       eng_rd_ack;
  logic       eng_done;
  logic       eng_ack;
  logic [7:0] eng_rdata;
  logic       busy;
  logic       err;
  logic       rd_valid;
  logic [7:0] rd_data;

  i2c_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_char(key_char),
    .btn(btn), .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
    .eng_rd_ack(eng_rd_ack), .eng_done(eng_done), .eng_ack(eng_ack),
    .eng_rdata(eng_rdata), .busy(busy), .err(err), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [2:0] log_op [64];
  logic [7:0] log_by [64];
  logic       log_ak [64];
  int         log_n = 0;
  int         nack_idx = -1;
  int         reads_seen = 0;

  logic [2:0] exp_op [64];
  logic [7:0] exp_by [64];
  logic       exp_ak [64];
  int         exp_n = 0;

  logic [7:0] rd_cap [16];
  int         rd_n = 0;
  int         err_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // engine model
  initial begin
    eng_done  = 1'b0;
    eng_ack   = 1'b1;
    eng_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (eng_req && !eng_done) begin
        if (log_n < 64) begin
          log_op[log_n] = eng_op;
          log_by[log_n] = eng_wdata;
          log_ak[log_n] = eng_rd_ack;
        end
        eng_ack   = (log_n != nack_idx);
        eng_rdata = 8'hC0 + 8'(reads_seen);
        if (eng_op == OP_READ) reads_seen++;
        log_n++;
        repeat (2) @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        eng_ack  = 1'b1;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid && rd_n < 16) begin
        rd_cap[rd_n] = rd_data;
        rd_n++;
      end
      if (err) err_cnt++;
    end
  end

  task automatic clear_logs();
    log_n = 0; exp_n = 0; rd_n = 0; reads_seen = 0; err_cnt = 0;
  endtask

  task automatic push(input logic [2:0] op, input logic [7:0] b, input logic ak);
    exp_op[exp_n] = op; exp_by[exp_n] = b; exp_ak[exp_n] = ak; exp_n++;
  endtask

  task automatic exp_frame(input logic [7:0] cmd);
    push(OP_START, 8'h00, 1'b1);
    push(OP_WRITE, 8'h12, 1'b1);
    push(OP_WRITE, cmd, 1'b1);
    push(OP_STOP, 8'h00, 1'b1);
  endtask

  task automatic exp_digit(input logic [7:0] d);
    push(OP_START, 8'h00, 1'b1);
    push(OP_WRITE, 8'h12, 1'b1);
    push(OP_WRITE, 8'h01, 1'b1);
    push(OP_WRITE, 8'h00, 1'b1);
    push(OP_WRITE, d, 1'b1);
    push(OP_STOP, 8'h00, 1'b1);
  endtask

  task automatic exp_bwrite();
    push(OP_START, 8'h00, 1'b1);
    push(OP_WRITE, 8'h12, 1'b1);
    push(OP_WRITE, 8'h02, 1'b1);
    push(OP_WRITE, 8'h00, 1'b1);
    for (int i = 1; i <= 8; i++) push(OP_WRITE, 8'(i), 1'b1);
    push(OP_STOP, 8'h00, 1'b1);
  endtask

  task automatic exp_bread();
    push(OP_START, 8'h00, 1'b1);
    push(OP_WRITE, 8'h12, 1'b1);
    push(OP_WRITE, 8'h0B, 1'b1);
    push(OP_WRITE, 8'h00, 1'b1);
    push(OP_RSTART, 8'h00, 1'b1);
    push(OP_WRITE, 8'h13, 1'b1);
    for (int i = 0; i < 8; i++) push(OP_READ, 8'h00, (i != 7));
    push(OP_STOP, 8'h00, 1'b1);
  endtask

  task automatic compare_log(input string tag);
    chk(log_n == exp_n, {tag, " op count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_op[i] == exp_op[i], $sformatf("%s op[%0d]", tag, i), log_op[i], exp_op[i]);
      if (exp_op[i] == OP_WRITE)
        chk(log_by[i] == exp_by[i], $sformatf("%s byte[%0d]", tag, i), log_by[i], exp_by[i]);
      if (exp_op[i] == OP_READ)
        chk(log_ak[i] == exp_ak[i], $sformatf("%s rd_ack[%0d]", tag, i), log_ak[i], exp_ak[i]);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic press_key(input logic [7:0] c);
    @(negedge clk);
    key_char  = c;
    key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic press_btn(input int i);
    @(negedge clk);
    btn[i] = 1'b1;
    @(negedge clk);
    btn = 4'b0000;
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk(eng_req == 1'b0, "R11 eng_req after reset", eng_req, 0);
    chk(err == 1'b0, "R8 err after reset", err, 0);
    chk(rd_valid == 1'b0, "R10 rd_valid after reset", rd_valid, 0);
  endtask

  task automatic t_key_digit(input logic [7:0] c);
    clear_logs();
    press_key(c);
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    wait_idle();
    exp_frame(8'h06); exp_digit(c - 8'h30); exp_frame(8'h04);
    compare_log($sformatf("R3 R6 R2 R1 key 0x%0h", c));
  endtask

  task automatic t_btn_digit(input int i, input logic [7:0] d);
    clear_logs();
    press_btn(i);
    wait_idle();
    exp_frame(8'h06); exp_digit(d); exp_frame(8'h04);
    compare_log($sformatf("R7 button %0d", i));
  endtask

  task automatic t_write(input bit use_btn);
    clear_logs();
    if (use_btn) press_btn(2); else press_key(8'h77);
    wait_idle();
    exp_frame(8'h06); exp_bwrite(); exp_frame(8'h04);
    compare_log(use_btn ? "R4 R6 btn write" : "R4 R6 key w");
  endtask

  task automatic t_read(input bit use_btn);
    clear_logs();
    if (use_btn) press_btn(3); else press_key(8'h72);
    wait_idle();
    exp_frame(8'h06); exp_bread(); exp_frame(8'h04);
    compare_log(use_btn ? "R5 R1 btn read" : "R5 R1 key r");
    chk(rd_n == 8, "R10 read byte count", rd_n, 8);
    for (int i = 0; i < 8 && i < rd_n; i++)
      chk(rd_cap[i] == 8'hC0 + 8'(i), $sformatf("R10 rd_data[%0d]", i), rd_cap[i], 8'hC0 + i);
  endtask

  task automatic t_ignored_key();
    clear_logs();
    press_key(8'h78);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R6 unmapped key busy", busy, 0);
    repeat (10) @(negedge clk);
    chk(log_n == 0, "R6 unmapped key ops", log_n, 0);
  endtask

  task automatic t_busy_ignore();
    clear_logs();
    press_key(8'h77);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R9 busy mid request", busy, 1);
    press_key(8'h72);
    press_btn(3);
    press_btn(0);
    wait_idle();
    exp_frame(8'h06); exp_bwrite(); exp_frame(8'h04);
    compare_log("R9 requests while busy");
    chk(rd_n == 0, "R9 no read started", rd_n, 0);
  endtask

  task automatic t_nack();
    clear_logs();
    nack_idx = 5;
    press_key(8'h35);
    wait_idle();
    nack_idx = -1;
    exp_frame(8'h06);
    push(OP_START, 8'h00, 1'b1);
    push(OP_WRITE, 8'h12, 1'b1);
    push(OP_STOP, 8'h00, 1'b1);
    compare_log("R8 nack abort");
    chk(err_cnt == 1, "R8 err pulse count", err_cnt, 1);
    chk(busy == 1'b0, "R8 idle after abort", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; key_valid = 1'b0; key_char = 8'h00; btn = 4'b0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_key_digit(8'h33);
    t_key_digit(8'h39);
    t_btn_digit(0, 8'h11);
    t_btn_digit(1, 8'h22);
    t_write(1'b0);
    t_write(1'b1);
    t_read(1'b0);
    t_read(1'b1);
    t_ignored_key();
    t_busy_ignore();
    t_nack();
    t_key_digit(8'h30);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule